// File: doc/BRIEF.md
# Multi-Channel Level/Edge Trigger Unit

This block watches a bus of logic input channels and decides, one strobed sample at a time, whether a trigger condition has been met. Software sets four masks:

- a channel-active mask;
- a trigger-enable mask;
- a mask that selects level or edge qualification for each channel;
- a polarity mask that selects high/falling versus low/rising.

After an arm pulse, the unit evaluates every strobed sample. The first sample on which every enabled channel meets its condition produces a single-cycle hit pulse. The unit then goes quiet until it is armed again.

Each channel has one of four conditions: level low, level high, rising edge or falling edge. An edge is judged against the previous strobed sample. At most one channel may be edge-qualified. A configuration with two or more edge channels raises an error flag and can never fire. When no active channel is enabled, the trigger is bypassed and the first strobed sample after arming fires at once.

Top module: `trig_unit`

## Requirements
- R1: An enabled, active channel with its level bit at 1 matches when its input equals its polarity bit. Polarity 0 means low and polarity 1 means high.
- R2: An enabled, active channel with its level bit at 0 is edge-qualified. Polarity 0 matches a 0-to-1 change and polarity 1 matches a 1-to-0 change, each between the previous strobed sample and the current one. The first strobed sample after an arm never produces an edge match.
- R3: The conditions of all enabled, active channels are combined with a logical AND. When they all hold on a strobed sample while the unit is armed, `trig_hit` is high for the one clock cycle after the strobe edge.
- R4: A channel whose channel-active bit is 0 takes no part in the trigger, whatever its enable, level, polarity and input values are.
- R5: When no channel is both enabled and active, the trigger is bypassed. The first strobed sample after arming produces the hit.
- R6: When two or more active channels are enabled and edge-qualified, `cfg_err` is high one cycle after such masks are presented, and no hit is produced for any sample taken with such masks. `cfg_err` returns low one cycle after the masks become valid again.
- R7: After a hit, no further hit occurs until the next arm pulse. The strobed sample, if any, in an arm cycle is discarded. The hit pulse never lasts more than one cycle.
- R8: After reset, `trig_hit` and `cfg_err` are low and the unit is disarmed, so strobed samples produce no hit until the first arm pulse.
- R9: Input samples in cycles without a strobe are ignored. They are neither evaluated nor used as the previous sample for edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | One-cycle pulse that (re)arms the unit and clears the edge history |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | NUM_CH | Input sample, one bit per channel |
| chan_mask | input | NUM_CH | Channel-active mask |
| en_mask | input | NUM_CH | Trigger-enable mask |
| lvl_mask | input | NUM_CH | 1 = level condition, 0 = edge condition |
| pol_mask | input | NUM_CH | 1 = high or falling, 0 = low or rising |
| trig_hit | output | 1 | One-cycle trigger pulse |
| cfg_err | output | 1 | More than one edge-qualified channel |

## Verification
A stale or wrongly updated previous-sample register shows up as a missing or spurious hit one cycle after the next strobed sample on an edge channel. Strobe-free cycles carrying changing data expose any update outside the strobe. An arm/fire state that fails to clear gives a second hit pulse, or a hit before arming, visible at the very next strobe. A broken edge counter shows on `cfg_err` one cycle after the masks change, and as a hit produced under a rejected configuration.

// File: rtl/trig_pkg.sv
// Shared types for the trigger unit.
// Assumes the per-channel condition is coded by {level bit, polarity bit}.
package trig_pkg;

    typedef enum logic [1:0] {
        COND_RISE = 2'b00,
        COND_FALL = 2'b01,
        COND_LOW  = 2'b10,
        COND_HIGH = 2'b11
    } chan_cond_e;

    // Map the two configuration bits of one channel onto its condition.
    function automatic chan_cond_e cond_of(input logic lvl, input logic pol);
        return chan_cond_e'({lvl, pol});
    endfunction

endpackage

// File: rtl/trig_chan_match.sv
// One channel's condition evaluator.
// Reports match=1 when the channel does not take part (inactive or not enabled)
// so that the caller can AND all channels. Purely combinational.
module trig_chan_match
    import trig_pkg::*;
(
    input  logic cur,      // current strobed sample bit
    input  logic prv,      // previous strobed sample bit
    input  logic prv_ok,   // previous sample exists since arming
    input  logic active,   // channel-active bit
    input  logic enable,   // trigger-enable bit
    input  logic lvl,      // level (1) or edge (0)
    input  logic pol,      // high/falling (1) or low/rising (0)
    output logic match
);

    chan_cond_e cond;

    // Decode the condition and evaluate it against the sample pair.
    always_comb begin
        cond = cond_of(lvl, pol);
        if (!(active && enable)) begin
            match = 1'b1;
        end else begin
            unique case (cond)
                COND_LOW:  match = !cur;
                COND_HIGH: match = cur;
                COND_RISE: match = prv_ok && !prv && cur;
                COND_FALL: match = prv_ok && prv && !cur;
                default:   match = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/trig_cfg_check.sv
// Configuration checker: flags more than one edge-qualified trigger channel
// and reports whether any channel takes part at all. Combinational.
module trig_cfg_check #(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic [NUM_CH-1:0] lvl_mask,
    output logic              edge_multi,
    output logic              any_enabled
);

    localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

    logic [NUM_CH-1:0] edge_bits;

    // Clearing the lowest set bit leaves something only if two or more were set.
    always_comb begin
        edge_bits   = chan_mask & en_mask & ~lvl_mask;
        edge_multi  = |(edge_bits & (edge_bits - ONE));
        any_enabled = |(chan_mask & en_mask);
    end

endmodule

// File: rtl/trig_sequencer.sv
// Arm/fire sequencer with the previous-sample register.
// Assumes all_match and edge_multi are combinational views of the current
// sample and masks. Arm has priority and discards a same-cycle sample.
module trig_sequencer #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [NUM_CH-1:0] smp_data,
    input  logic              all_match,
    input  logic              edge_multi,
    output logic [NUM_CH-1:0] prev_data,
    output logic              prev_ok,
    output logic              trig_hit,
    output logic              cfg_err
);

    typedef enum logic {ST_IDLE, ST_ARMED} seq_state_e;

    seq_state_e state;

    // Arm, capture strobed samples, fire once and drop back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            prev_data <= '0;
            prev_ok   <= 1'b0;
            trig_hit  <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            trig_hit <= 1'b0;
            cfg_err  <= edge_multi;
            if (arm) begin
                state   <= ST_ARMED;
                prev_ok <= 1'b0;
            end else if (smp_valid && state == ST_ARMED) begin
                prev_data <= smp_data;
                prev_ok   <= 1'b1;
                if (all_match && !edge_multi) begin
                    trig_hit <= 1'b1;
                    state    <= ST_IDLE;
                end
            end
        end
    end

endmodule

// File: rtl/trig_unit.sv
// Multi-channel level/edge trigger unit (top).
// One condition evaluator per channel, an edge-count checker and the
// arm/fire sequencer. Masks are assumed stable while samples are evaluated.
module trig_unit #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [NUM_CH-1:0] smp_data,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic [NUM_CH-1:0] en_mask,
    input  logic [NUM_CH-1:0] lvl_mask,
    input  logic [NUM_CH-1:0] pol_mask,
    output logic              trig_hit,
    output logic              cfg_err
);

    logic [NUM_CH-1:0] chan_match;
    logic [NUM_CH-1:0] prev_data;
    logic              prev_ok;
    logic              edge_multi;
    logic              any_enabled;
    logic              all_match;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        trig_chan_match u_match (
            .cur    (smp_data[g]),
            .prv    (prev_data[g]),
            .prv_ok (prev_ok),
            .active (chan_mask[g]),
            .enable (en_mask[g]),
            .lvl    (lvl_mask[g]),
            .pol    (pol_mask[g]),
            .match  (chan_match[g])
        );
    end

    trig_cfg_check #(.NUM_CH(NUM_CH)) u_cfg (
        .chan_mask   (chan_mask),
        .en_mask     (en_mask),
        .lvl_mask    (lvl_mask),
        .edge_multi  (edge_multi),
        .any_enabled (any_enabled)
    );

    // AND of all channel conditions; with nothing enabled the unit is bypassed.
    always_comb begin
        all_match = any_enabled ? (&chan_match) : 1'b1;
    end

    trig_sequencer #(.NUM_CH(NUM_CH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .all_match  (all_match),
        .edge_multi (edge_multi),
        .prev_data  (prev_data),
        .prev_ok    (prev_ok),
        .trig_hit   (trig_hit),
        .cfg_err    (cfg_err)
    );

endmodule

// File: rtl/trig_unit_chk.sv
// Property checker for trig_unit, attached by bind.
// Assumes a synchronous active-low reset.
module trig_unit_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              smp_valid,
    input logic [NUM_CH-1:0] chan_mask,
    input logic [NUM_CH-1:0] en_mask,
    input logic [NUM_CH-1:0] lvl_mask,
    input logic              edge_multi,
    input logic              trig_hit,
    input logic              cfg_err
);

    logic past_ok;
    logic since_hit;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // Tracks a hit not yet followed by an arm.
    always_ff @(posedge clk) begin
        if (!rst_n)         since_hit <= 1'b0;
        else if (arm)       since_hit <= 1'b0;
        else if (trig_hit)  since_hit <= 1'b1;
    end

    p_hit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> !trig_hit);

    p_quiet_until_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        since_hit |-> !trig_hit);

    p_hit_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trig_hit) |-> $past(smp_valid && !arm));

    p_err_blocks_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && trig_hit) |-> !$past(edge_multi));

    p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cfg_err) |-> $past($countones(chan_mask & en_mask & ~lvl_mask) > 1));

    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !cfg_err) |-> !$past($countones(chan_mask & en_mask & ~lvl_mask) > 1));

endmodule

bind trig_unit trig_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .smp_valid  (smp_valid),
    .chan_mask  (chan_mask),
    .en_mask    (en_mask),
    .lvl_mask   (lvl_mask),
    .edge_multi (edge_multi),
    .trig_hit   (trig_hit),
    .cfg_err    (cfg_err)
);

// File: tb/test_trig_unit.sv
// Bench: sweeps all five modes (off/low/high/rise/fall) on three channels
// with pseudo-random strobed and unstrobed samples, plus directed cases.
module test_trig_unit;

    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm = 1'b0;
    logic           smp_valid = 1'b0;
    logic [NCH-1:0] smp_data = '0;
    logic [NCH-1:0] chan_mask = '1;
    logic [NCH-1:0] en_mask = '0;
    logic [NCH-1:0] lvl_mask = '0;
    logic [NCH-1:0] pol_mask = '0;
    logic           trig_hit;
    logic           cfg_err;

    int total = 0;
    int bad = 0;
    logic [31:0] lfsr = 32'hACE1_2461;

    // Reference model state
    bit m_armed = 0;
    bit m_prev_ok = 0;
    logic [NCH-1:0] m_prev = '0;
    int modes [3];
    bit trick = 0;

    always #4 clk = ~clk;

    trig_unit #(.NUM_CH(NCH)) i_trig_unit (
        .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .chan_mask(chan_mask), .en_mask(en_mask),
        .lvl_mask(lvl_mask), .pol_mask(pol_mask),
        .trig_hit(trig_hit), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return v[0] ? ((v >> 1) ^ 32'hA300_0001) : (v >> 1);
    endfunction

    function automatic bit mode_ok(input int m, input bit cur, input bit prv, input bit pok);
        case (m)
            1: return !cur;
            2: return cur;
            3: return pok && !prv && cur;
            4: return pok && prv && !cur;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int n_edges();
        int n = 0;
        for (int i = 0; i < 3; i++) if (modes[i] >= 3) n++;
        return n;
    endfunction

    // Load the three swept channels' modes into the masks.
    task automatic load_modes();
        en_mask = '0; lvl_mask = '0; pol_mask = '0; chan_mask = '1;
        for (int i = 0; i < 3; i++) begin
            en_mask[i]  = (modes[i] != 0);
            lvl_mask[i] = (modes[i] == 1) || (modes[i] == 2);
            pol_mask[i] = (modes[i] == 2) || (modes[i] == 4);
        end
        if (trick) begin
            // Channel 3 enabled high-level but inactive; its input stays low.
            en_mask[3] = 1'b1; lvl_mask[3] = 1'b1; pol_mask[3] = 1'b1;
            chan_mask[3] = 1'b0;
        end
    endtask

    // Arm pulse; afterwards check the registered error flag.
    task automatic do_arm(input string tag);
        @(negedge clk);
        arm = 1'b1; smp_valid = 1'b0;
        @(negedge clk);
        arm = 1'b0;
        m_armed = 1; m_prev_ok = 0;
        chk(cfg_err == (n_edges() > 1), tag, cfg_err, n_edges() > 1);
    endtask

    // One cycle of input; hit is checked at the following negedge.
    task automatic step(input bit v, input logic [NCH-1:0] d, input string tag);
        bit e = 0;
        bit all;
        smp_valid = v; smp_data = d;
        if (v && m_armed) begin
            all = 1;
            for (int i = 0; i < 3; i++)
                all &= mode_ok(modes[i], d[i], m_prev[i], m_prev_ok);
            e = all && (n_edges() <= 1);
            m_prev = d; m_prev_ok = 1;
            if (e) m_armed = 0;
        end
        @(negedge clk);
        chk(trig_hit == e, tag, trig_hit, e);
        smp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(trig_hit == 1'b0, "R8", trig_hit, 0);
        chk(cfg_err == 1'b0, "R8", cfg_err, 0);
        rst_n = 1'b1;
        // R8: unarmed after reset, a matching level sample must not fire
        modes[0] = 2; modes[1] = 0; modes[2] = 0; trick = 0; load_modes();
        @(negedge clk);
        step(1, 16'h0001, "R8");
        step(1, 16'h0001, "R8");

        // R3/R7: level fire, single pulse, quiet until re-arm
        do_arm("R6");
        step(1, 16'h0001, "R3");
        step(1, 16'h0001, "R7");
        step(1, 16'h0001, "R7");
        do_arm("R6");
        step(1, 16'h0001, "R7");

        // R7: sample in arm cycle is discarded
        @(negedge clk);
        arm = 1'b1; smp_valid = 1'b1; smp_data = 16'h0001;
        @(negedge clk);
        arm = 1'b0; smp_valid = 1'b0;
        m_armed = 1; m_prev_ok = 0;
        chk(trig_hit == 1'b0, "R7", trig_hit, 0);
        step(1, 16'h0001, "R7");

        // R9: rise on ch0 with an unstrobed 1 in between
        modes[0] = 3; load_modes();
        do_arm("R6");
        step(1, 16'h0000, "R9");
        step(0, 16'h0001, "R9");
        step(1, 16'h0001, "R9");

        // R2: first sample after arm cannot edge-match
        do_arm("R6");
        step(1, 16'h0001, "R2");
        step(1, 16'h0000, "R2");
        step(1, 16'h0001, "R2");

        // R5: bypass with nothing enabled
        modes[0] = 0; load_modes();
        do_arm("R5");
        step(1, 16'h0000, "R5");

        // R4: only an inactive channel enabled behaves as bypass
        trick = 1; load_modes();
        do_arm("R4");
        step(1, 16'h0000, "R4");
        trick = 0;

        // R6: two edge channels, then back to one
        modes[0] = 3; modes[1] = 4; load_modes();
        do_arm("R6");
        step(1, 16'h0000, "R6");
        step(1, 16'h0001, "R6");
        modes[1] = 0; load_modes();
        @(negedge clk);
        chk(cfg_err == 1'b0, "R6", cfg_err, 0);

        // R1/R2/R3/R4/R6 sweep: all 5^3 mode combinations
        for (int c = 0; c < 125; c++) begin
            string tag;
            modes[0] = c % 5; modes[1] = (c / 5) % 5; modes[2] = c / 25;
            trick = c[0];
            load_modes();
            if (n_edges() > 1) tag = "R6";
            else if (trick) tag = "R4";
            else if (n_edges() == 1) tag = "R2";
            else if (modes[0] == 0 && modes[1] == 0 && modes[2] == 0) tag = "R5";
            else tag = "R1";
            do_arm(tag);
            for (int s = 0; s < 20; s++) begin
                logic [NCH-1:0] d;
                lfsr = nxt(lfsr);
                d = lfsr[NCH-1:0];
                if (trick) d[3] = 1'b0;
                step(lfsr[20] | lfsr[27], d, tag);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule